// File: doc/BRIEF.md
# Serial Receive FIFO with Interrupt Trigger

This block buffers words that a serial shift engine has received until software collects them. The shift engine hands over each completed word with a one-cycle valid strobe. Software sees the queue through one buffer port: `rd_data` always shows the oldest unread word, and a read strobe removes it. The block reports a fill level and a sticky overrun flag, and it emits a one-cycle interrupt pulse. That pulse fires when the level reaches a programmable trigger, when the queue overflows, and when software reads an empty queue.

On overflow the newest stored word is replaced, so the oldest words are kept and the most recent word is always current. With the queue disabled, the block falls back to a single holding register that behaves like a plain receive buffer. The stored word width is selectable from 2 to 16 bits, and bits above that width are cleared when the word is stored. The depth is a parameter and must be a power of two; it defaults to 8.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset, `fill_lvl` is 0 and `rx_irq` and `rx_err` are 0.
- R2: In queue mode (`fifo_en`=1), `rd_data` shows the oldest unread word, and each `rd_req` strobe removes it, so words come out in arrival order.
- R3: In queue mode, `fill_lvl` counts the words written and not yet read, and never exceeds the depth. A write and a read in the same cycle on a non-empty queue leave it unchanged.
- R4: `rx_irq` is a one-cycle pulse in the cycle after its cause. In queue mode, a write that leaves the level at or above `trig_lvl` is a cause, and no other write is.
- R5: A write to a full queue with no read in that cycle replaces the most recently stored word. The level stays at the depth and `rx_irq` pulses.
- R6: Such an overflow write sets `rx_err` when `err_en`=1 and leaves it clear when `err_en`=0. `rx_err` stays set until a flush.
- R7: A read of an empty queue in queue mode pulses `rx_irq`, keeps the level at 0 and returns `rd_data`=0.
- R8: `flush` empties the queue and the holding register and clears `rx_err`. It overrides a write or read in the same cycle, which then raises no interrupt.
- R9: `word_bits` (2..16) sets the stored width. `rd_data` bits at positions `word_bits` and above read 0.
- R10: With `fifo_en`=0, each write replaces the holding register and pulses `rx_irq`. The level is 0 or 1. A write while the held word is unread sets `rx_err` if `err_en`=1. An empty read raises no interrupt.
- R11: With `trig_lvl`=3, interrupts follow the third and fourth writes. After three reads leave one word, the next interrupt follows the second further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 selects queue mode, 0 selects the single holding register |
| trig_lvl | input | 4 | Fill level at which writes raise an interrupt |
| err_en | input | 1 | Allows overrun to set the error flag |
| flush | input | 1 | One-cycle strobe that empties all storage |
| word_bits | input | 5 | Stored word width, 2 to 16 |
| wr_vld | input | 1 | Received word strobe |
| wr_data | input | 16 | Received word |
| rd_req | input | 1 | Buffer read strobe, pops the oldest word |
| rd_data | output | 16 | Oldest unread word, 0 when empty |
| fill_lvl | output | 4 | Number of unread words |
| rx_err | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The assertions assume that `fifo_en` and `word_bits` change only while the storage is empty. They also assume that `word_bits` stays within 2 to 16. Under those conditions, a level that holds steady and the cleared upper bits are meaningful properties rather than effects of reconfiguration. The stimulus flushes before every change of mode and changes the width only after the queue has been drained. The interrupt checks assume that every pulse comes from a write or read strobe in the previous cycle. The bench therefore drives each strobe for exactly one cycle and leaves the strobes idle while it sets up.

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig #(
  parameter int DEPTH = 8,
  parameter int WMAX  = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int BW = $clog2(WMAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fifo_en,
  input  logic [LW-1:0]   trig_lvl,
  input  logic            err_en,
  input  logic            flush,
  input  logic [BW-1:0]   word_bits,
  input  logic            wr_vld,
  input  logic [WMAX-1:0] wr_data,
  input  logic            rd_req,
  output logic [WMAX-1:0] rd_data,
  output logic [LW-1:0]   fill_lvl,
  output logic            rx_err,
  output logic            rx_irq
);

  logic [WMAX-1:0] mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [LW-1:0]   cnt;
  logic [WMAX-1:0] hold;
  logic            hfull;

  wire [WMAX-1:0] mask  = ~({WMAX{1'b1}} << word_bits);
  wire [WMAX-1:0] din   = wr_data & mask;
  wire            full  = cnt == LW'(DEPTH);
  wire            empty = cnt == '0;

  wire pop  = fifo_en & rd_req & ~empty;
  wire ovw  = fifo_en & wr_vld & full & ~rd_req;
  wire push = fifo_en & wr_vld & ~ovw;

  wire [LW-1:0] cnt_nx = cnt + LW'(push) - LW'(pop);

  wire irq_q  = (wr_vld & ((cnt_nx >= trig_lvl) | ovw)) | (rd_req & empty);
  wire irq_nx = fifo_en ? irq_q : wr_vld;
  wire err_nx = err_en & (fifo_en ? ovw : (wr_vld & hfull & ~rd_req));

  always_ff @(posedge clk) begin
    if (push)
      mem[wp] <= din;
    else if (ovw)
      mem[wp - PW'(1)] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      hold   <= '0;
      hfull  <= 1'b0;
      rx_err <= 1'b0;
      rx_irq <= 1'b0;
    end else if (flush) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      hfull  <= 1'b0;
      rx_err <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      if (push) wp <= wp + PW'(1);
      if (pop)  rp <= rp + PW'(1);
      cnt <= cnt_nx;
      if (!fifo_en) begin
        if (wr_vld) begin
          hold  <= din;
          hfull <= 1'b1;
        end else if (rd_req) begin
          hfull <= 1'b0;
        end
      end
      if (err_nx) rx_err <= 1'b1;
      rx_irq <= irq_nx;
    end
  end

  assign rd_data  = fifo_en ? (empty ? '0 : mem[rp]) : (hfull ? hold : '0);
  assign fill_lvl = fifo_en ? cnt : LW'(hfull);

endmodule

// File: rtl/rx_fifo_trig_chk.sv
module rx_fifo_trig_chk #(
  parameter int DEPTH = 8,
  parameter int WMAX  = 16,
  parameter int LW    = 4,
  parameter int BW    = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fifo_en,
  input logic            err_en,
  input logic            flush,
  input logic [BW-1:0]   word_bits,
  input logic            wr_vld,
  input logic            rd_req,
  input logic [WMAX-1:0] rd_data,
  input logic [LW-1:0]   fill_lvl,
  input logic            rx_err,
  input logic            rx_irq
);

  AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_lvl <= LW'(DEPTH)); // R3

  AST_SIM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !flush && wr_vld && rd_req && fill_lvl != '0) |=> fill_lvl == $past(fill_lvl)); // R3

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(wr_vld || rd_req)); // R4

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !flush && wr_vld && !rd_req && fill_lvl == LW'(DEPTH)) |=> (fill_lvl == LW'(DEPTH) && rx_irq)); // R5

  AST_OVF_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !flush && err_en && wr_vld && !rd_req && fill_lvl == LW'(DEPTH)) |=> rx_err); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !flush) |=> rx_err); // R6

  AST_EMPTY_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !flush && rd_req && fill_lvl == '0) |=> rx_irq); // R7

  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill_lvl == '0 && !rx_irq && !rx_err)); // R8

  AST_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data >> word_bits) == '0); // R9

  AST_OFF_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> fill_lvl <= LW'(1)); // R10

endmodule

bind rx_fifo_trig rx_fifo_trig_chk #(.DEPTH(DEPTH), .WMAX(WMAX), .LW(LW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .err_en(err_en), .flush(flush),
  .word_bits(word_bits), .wr_vld(wr_vld), .rd_req(rd_req), .rd_data(rd_data),
  .fill_lvl(fill_lvl), .rx_err(rx_err), .rx_irq(rx_irq)
);

// File: tb/sim_rx_fifo_trig.sv
`timescale 1ns/1ps
module sim_rx_fifo_trig;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b1;
  logic [3:0]  trig_lvl = 4'd8;
  logic        err_en = 1'b0;
  logic        flush = 1'b0;
  logic [4:0]  word_bits = 5'd16;
  logic        wr_vld = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic [15:0] rd_data;
  logic [3:0]  fill_lvl;
  logic        rx_err, rx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_fifo_trig u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_lvl(trig_lvl),
    .err_en(err_en), .flush(flush), .word_bits(word_bits), .wr_vld(wr_vld),
    .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data), .fill_lvl(fill_lvl),
    .rx_err(rx_err), .rx_irq(rx_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [15:0] d, input logic r);
    wr_vld = w; wr_data = d; rd_req = r;
    @(negedge clk);
    wr_vld = 1'b0; rd_req = 1'b0;
  endtask

  task automatic push(input logic [15:0] d);
    cyc(1'b1, d, 1'b0);
  endtask

  task automatic pop_exp(input string tag, input logic [15:0] e);
    chk(tag, rd_data, e);
    cyc(1'b0, '0, 1'b1);
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 level", fill_lvl, 0);
    chk("R1 irq", rx_irq, 0);
    chk("R1 err", rx_err, 0);
  endtask

  task automatic t_order();
    do_flush(); trig_lvl = 4'd8;
    for (int i = 0; i < 5; i++) begin
      push(16'h100 + 16'(i));
      chk("R4 below trigger no irq", rx_irq, 0);
    end
    chk("R3 level five", fill_lvl, 5);
    for (int i = 0; i < 5; i++) pop_exp("R2 order", 16'h100 + 16'(i));
    chk("R3 level drained", fill_lvl, 0);
  endtask

  task automatic t_example();
    do_flush(); trig_lvl = 4'd3;
    push(16'hA); chk("R11 first", rx_irq, 0);
    push(16'hB); chk("R11 second", rx_irq, 0);
    push(16'hC); chk("R11 third irq", rx_irq, 1);
    push(16'hD); chk("R11 fourth irq", rx_irq, 1);
    pop_exp("R11 read A", 16'hA); chk("R4 read no irq", rx_irq, 0);
    pop_exp("R11 read B", 16'hB);
    pop_exp("R11 read C", 16'hC);
    chk("R11 one left", fill_lvl, 1);
    push(16'hE); chk("R11 fifth no irq", rx_irq, 0);
    push(16'hF); chk("R11 sixth irq", rx_irq, 1);
    pop_exp("R11 read D", 16'hD);
    pop_exp("R11 read E", 16'hE);
    pop_exp("R11 read F", 16'hF);
    chk("R11 last read no irq", rx_irq, 0);
    chk("R11 empty", fill_lvl, 0);
    chk("R7 empty data", rd_data, 0);
    cyc(1'b0, '0, 1'b1);
    chk("R7 empty read irq", rx_irq, 1);
    chk("R7 level stays zero", fill_lvl, 0);
  endtask

  task automatic t_simul();
    do_flush(); trig_lvl = 4'd8;
    push(16'hA1); push(16'hA2);
    chk("R2 head", rd_data, 16'hA1);
    cyc(1'b1, 16'hA3, 1'b1);
    chk("R3 simultaneous level", fill_lvl, 2);
    pop_exp("R2 after simultaneous", 16'hA2);
    pop_exp("R2 tail", 16'hA3);
  endtask

  task automatic t_overflow();
    do_flush(); trig_lvl = 4'd8; err_en = 1'b0;
    for (int i = 1; i <= 7; i++) push(16'(i));
    chk("R4 seven below trigger", rx_irq, 0);
    push(16'd8);
    chk("R4 at trigger irq", rx_irq, 1);
    push(16'd9);
    chk("R5 level full", fill_lvl, 8);
    chk("R5 overflow irq", rx_irq, 1);
    chk("R6 disabled no err", rx_err, 0);
    err_en = 1'b1;
    push(16'd10);
    chk("R6 err set", rx_err, 1);
    for (int i = 1; i <= 7; i++) pop_exp("R5 kept old words", 16'(i));
    pop_exp("R5 last overwritten", 16'd10);
    chk("R6 sticky", rx_err, 1);
    do_flush();
    chk("R8 flush clears err", rx_err, 0);
    err_en = 1'b0;
  endtask

  task automatic t_flush();
    do_flush(); trig_lvl = 4'd1;
    push(16'h31); push(16'h32); push(16'h33);
    flush = 1'b1; wr_vld = 1'b1; wr_data = 16'h34; rd_req = 1'b1;
    @(negedge clk);
    flush = 1'b0; wr_vld = 1'b0; rd_req = 1'b0;
    chk("R8 level zero", fill_lvl, 0);
    chk("R8 no irq", rx_irq, 0);
    chk("R8 data zero", rd_data, 0);
  endtask

  task automatic t_mask();
    do_flush(); trig_lvl = 4'd8; word_bits = 5'd4;
    push(16'hFFFF);
    pop_exp("R9 four bits", 16'h000F);
    word_bits = 5'd2;
    push(16'h1235);
    pop_exp("R9 two bits", 16'h0001);
    word_bits = 5'd16;
    push(16'hBEEF);
    pop_exp("R9 full width", 16'hBEEF);
  endtask

  task automatic t_off();
    do_flush(); fifo_en = 1'b0; err_en = 1'b1;
    push(16'h11);
    chk("R10 irq each write", rx_irq, 1);
    chk("R10 level one", fill_lvl, 1);
    chk("R10 no err", rx_err, 0);
    push(16'h22);
    chk("R10 err unread", rx_err, 1);
    chk("R10 level still one", fill_lvl, 1);
    pop_exp("R10 replaced", 16'h22);
    chk("R10 level zero", fill_lvl, 0);
    cyc(1'b0, '0, 1'b1);
    chk("R10 empty read no irq", rx_irq, 0);
    do_flush(); fifo_en = 1'b1; err_en = 1'b0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_example();
    t_simul();
    t_overflow();
    t_flush();
    t_mask();
    t_off();
    report();
  end
endmodule